// File: doc/BRIEF.md
# Integer Execute Unit

This block is a single-cycle execute stage for the base 32-bit integer instructions. These are the register-register ALU operations, the register-immediate ALU operations, and the two upper-immediate forms (load-upper and add-upper-to-PC). Each cycle it receives a raw instruction word, a valid strobe and the program counter of that instruction. It decodes the word and reads both source operands from an internal register file. It computes the result and writes it to the destination register on the next rising clock edge.

The upper-immediate instructions use the same adder as the ALU operations. Load-upper adds its immediate to zero, and add-upper-to-PC adds its immediate to the PC. Any opcode outside the supported set raises an illegal flag in the same cycle and does not write the register file. A separate debug port reads any register at any time without disturbing the rest of the block.

Top module: `exu_core`

## Requirements
- R1: Opcode bits [6:0] select the path: 0x13 register-immediate ALU, 0x33 register-register ALU, 0x37 load-upper, 0x17 add-upper-to-PC. Any other value with valid high drives illegal_o high in that cycle and leaves every register unchanged. illegal_o is low whenever valid is low.
- R2: Bits [14:12] select the ALU function: 0 add, 1 shift left, 2 signed less-than, 3 unsigned less-than, 4 xor, 5 shift right, 6 or, 7 and. Both register fields sit at bits [19:15] (rs1) and [24:20] (rs2), and rd sits at [11:7].
- R3: Instruction bit 30 turns a register-register add into a subtract, and it turns a right shift (either format) into an arithmetic shift. For a register-immediate add, bit 30 is only part of the immediate.
- R4: The shift amount is the low 5 bits of the immediate or of the rs2 value, and all higher bits are ignored. A shift of zero returns rs1 unchanged.
- R5: Less-than operations write 1 or 0. The signed form compares as two's complement. The unsigned form compares rs1 with rs2, or with the sign-extended immediate, as unsigned numbers.
- R6: The register-immediate operand is bits [31:20] sign-extended to 32 bits.
- R7: Load-upper writes bits [31:12] followed by twelve zero bits. Add-upper-to-PC writes that value plus pc_i.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: A write happens only on a rising edge with valid high. An active-low reset clears every register to zero.
- R10: Source reads are combinational, so an instruction that reads the previous instruction's destination sees the new value.
- R11: dbg_addr_i selects a register whose current value appears on dbg_data_o combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Raw instruction word |
| pc_i | input | 32 | Address of the instruction |
| dbg_addr_i | input | 5 | Debug register select |
| dbg_data_o | output | 32 | Debug register value |
| illegal_o | output | 1 | Unsupported opcode while valid |

## Verification
The bench builds the unit with its default 32-bit width and 32-entry register file. At that size the real instruction encodings apply unchanged, so the bench can issue encoded words directly. These include the sign-extended immediates, bit-30 variants, oversized shift fields and the PC-relative upper immediate. The bench builds operand values through load-upper/add-immediate pairs. This means the sign-boundary comparisons and the shift patterns on negative operands are all reached through the instruction path alone.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int unsigned ILEN = 32;

  typedef enum logic [6:0] {
    OPC_OP_IMM = 7'h13,
    OPC_OP     = 7'h33,
    OPC_LUI    = 7'h37,
    OPC_AUIPC  = 7'h17
  } opc_e;

  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_SLL  = 3'd1,
    FN_SLT  = 3'd2,
    FN_SLTU = 3'd3,
    FN_XOR  = 3'd4,
    FN_SR   = 3'd5,
    FN_OR   = 3'd6,
    FN_AND  = 3'd7
  } alu_fn_e;

  typedef enum logic [1:0] {
    SRC_A_REG  = 2'd0,
    SRC_A_PC   = 2'd1,
    SRC_A_ZERO = 2'd2
  } src_a_e;

  typedef struct packed {
    logic [4:0]      rs1;
    logic [4:0]      rs2;
    logic [4:0]      rd;
    alu_fn_e         fn;
    logic            alt;
    src_a_e          a_sel;
    logic            b_imm;
    logic [ILEN-1:0] imm;
    logic            we;
    logic            illegal;
  } dec_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic            valid_i,
  input  logic [ILEN-1:0] instr_i,
  output dec_t            dec_o
);
  alu_fn_e         f3;
  logic [ILEN-1:0] imm_i;
  logic [ILEN-1:0] imm_u;

  assign f3    = alu_fn_e'(instr_i[14:12]);
  assign imm_i = {{20{instr_i[31]}}, instr_i[31:20]};
  assign imm_u = {instr_i[31:12], 12'b0};

  always_comb begin
    dec_o         = '0;
    dec_o.rs1     = instr_i[19:15];
    dec_o.rs2     = instr_i[24:20];
    dec_o.rd      = instr_i[11:7];
    dec_o.fn      = FN_ADD;
    dec_o.a_sel   = SRC_A_REG;
    case (instr_i[6:0])
      OPC_OP_IMM: begin
        dec_o.fn    = f3;
        dec_o.alt   = (f3 == FN_SR) && instr_i[30];
        dec_o.b_imm = 1'b1;
        dec_o.imm   = imm_i;
        dec_o.we    = valid_i;
      end
      OPC_OP: begin
        dec_o.fn    = f3;
        dec_o.alt   = ((f3 == FN_SR) || (f3 == FN_ADD)) && instr_i[30];
        dec_o.we    = valid_i;
      end
      OPC_LUI: begin
        dec_o.a_sel = SRC_A_ZERO;
        dec_o.b_imm = 1'b1;
        dec_o.imm   = imm_u;
        dec_o.we    = valid_i;
      end
      OPC_AUIPC: begin
        dec_o.a_sel = SRC_A_PC;
        dec_o.b_imm = 1'b1;
        dec_o.imm   = imm_u;
        dec_o.we    = valid_i;
      end
      default: dec_o.illegal = valid_i;
    endcase
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_fn_e         fn_i,
  input  logic            alt_i,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned SHW = $clog2(XLEN);

  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] shr;
  logic            lt_s;
  logic            lt_u;

  assign shamt = b_i[SHW-1:0];
  assign sum   = alt_i ? (a_i - b_i) : (a_i + b_i);
  assign lt_s  = $signed(a_i) < $signed(b_i);
  assign lt_u  = a_i < b_i;
  assign shr   = alt_i ? XLEN'($signed(a_i) >>> shamt) : (a_i >> shamt);

  always_comb begin
    case (fn_i)
      FN_ADD:  res_o = sum;
      FN_SLL:  res_o = a_i << shamt;
      FN_SLT:  res_o = {{(XLEN-1){1'b0}}, lt_s};
      FN_SLTU: res_o = {{(XLEN-1){1'b0}}, lt_u};
      FN_XOR:  res_o = a_i ^ b_i;
      FN_SR:   res_o = shr;
      FN_OR:   res_o = a_i | b_i;
      FN_AND:  res_o = a_i & b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/exu_regfile.sv
module exu_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  parameter int unsigned NRP  = 3,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [XLEN-1:0]          wdata_i,
  input  logic [NRP-1:0][AW-1:0]   raddr_i,
  output logic [NRP-1:0][XLEN-1:0] rdata_o
);
  logic [NREG-1:0][XLEN-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else if (we_i && (waddr_i != '0)) regs_q[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : regs_q[raddr_i[p]];
  end

  // R9
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> regs_q[$past(waddr_i)] == $past(wdata_i));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q));
  // R8
  x0_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == '0) |=> $stable(regs_q));
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [AW-1:0]   dbg_addr_i,
  output logic [XLEN-1:0] dbg_data_o,
  output logic            illegal_o
);
  localparam int unsigned NRP = 3;

  dec_t                     dec;
  logic [NRP-1:0][AW-1:0]   raddr;
  logic [NRP-1:0][XLEN-1:0] rdata;
  logic [XLEN-1:0]          op_a;
  logic [XLEN-1:0]          op_b;
  logic [XLEN-1:0]          alu_res;

  exu_decode u_dec (
    .valid_i (valid_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  assign raddr[0] = AW'(dec.rs1);
  assign raddr[1] = AW'(dec.rs2);
  assign raddr[2] = dbg_addr_i;

  exu_regfile #(.XLEN(XLEN), .NREG(NREG), .NRP(NRP)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dec.we),
    .waddr_i (AW'(dec.rd)),
    .wdata_i (alu_res),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  always_comb begin
    case (dec.a_sel)
      SRC_A_PC:   op_a = pc_i;
      SRC_A_ZERO: op_a = '0;
      default:    op_a = rdata[0];
    endcase
  end

  assign op_b = dec.b_imm ? XLEN'(dec.imm) : rdata[1];

  exu_alu #(.XLEN(XLEN)) u_alu (
    .a_i   (op_a),
    .b_i   (op_b),
    .fn_i  (dec.fn),
    .alt_i (dec.alt),
    .res_o (alu_res)
  );

  assign dbg_data_o = rdata[2];
  assign illegal_o  = dec.illegal;

  // R1
  illegal_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !dec.we);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!illegal_o && !dec.we));
  // R3
  sra_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.fn == FN_SR && dec.alt && op_a[XLEN-1]) |-> alu_res[XLEN-1]);
  // R4
  srl_shrinks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.fn == FN_SR && !dec.alt) |-> (alu_res <= op_a));
endmodule

// File: tb/exu_core_test.sv
module exu_core_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_i = '0;
  logic [4:0]  dbg_addr_i = '0;
  logic [31:0] dbg_data_o;
  logic        illegal_o;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [4:0]  rd;
    logic [31:0] val;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #5 clk_i = ~clk_i;

  exu_core uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .dbg_addr_i(dbg_addr_i), .dbg_data_o(dbg_data_o),
    .illegal_o(illegal_o)
  );

  function automatic logic [31:0] enc_i(input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [4:0] rs1, input logic [11:0] imm);
    return {imm, rs1, f3, rd, 7'h13};
  endfunction
  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [4:0] rs1,
                                        input logic [4:0] rs2);
    return {f7, rs2, rs1, f3, rd, 7'h33};
  endfunction
  function automatic logic [31:0] enc_u(input logic [6:0] opc, input logic [4:0] rd,
                                        input logic [19:0] imm);
    return {imm, rd, opc};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [31:0] pc, input logic vld,
                       input logic exp_ill, input logic [4:0] rd, input logic [31:0] val,
                       input string req);
    @(negedge clk_i);
    instr_i = ins; pc_i = pc; valid_i = vld;
    #1 check({req, " illegal"}, {31'b0, illegal_o}, {31'b0, exp_ill});
    @(posedge clk_i);
    #1 sb.push_back('{rd: rd, val: val, req: req});
  endtask

  task automatic set_reg(input logic [4:0] rd, input logic [31:0] v);
    logic [31:0] hi;
    hi = v - {{20{v[11]}}, v[11:0]};
    issue(enc_u(7'h37, rd, hi[31:12]), 0, 1, 0, rd, hi, "R7 setup");
    issue(enc_i(3'd0, rd, rd, v[11:0]), 0, 1, 0, rd, v, "R6 setup");
  endtask

  // monitor: one expected item per cycle
  initial begin
    forever begin
      @(negedge clk_i);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        dbg_addr_i = e.rd;
        #1 check(e.req, dbg_data_o, e.val);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 R11: reset state visible on debug port
    dbg_addr_i = 5'd1;
    #1 check("R9 reset x1", dbg_data_o, 32'h0);
    dbg_addr_i = 5'd31;
    #1 check("R11 reset x31", dbg_data_o, 32'h0);
    rst_ni = 1'b1;

    // R6
    issue(32'h00500093, 0, 1, 0, 5'd1, 32'd5, "R6 addi 5");
    issue(32'hFFE00093, 0, 1, 0, 5'd1, 32'hFFFFFFFE, "R6 addi -2");
    // R3: bit 30 inside the add immediate is just data
    issue(enc_i(3'd0, 5'd3, 5'd0, 12'h400), 0, 1, 0, 5'd3, 32'd1024, "R3 addi bit30");

    // R5
    set_reg(5'd1, 32'd5);
    issue(enc_i(3'd3, 5'd2, 5'd1, 12'd15), 0, 1, 0, 5'd2, 32'd1, "R5 sltiu 5<15");
    issue(enc_i(3'd3, 5'd2, 5'd1, 12'd5),  0, 1, 0, 5'd2, 32'd0, "R5 sltiu 5<5");
    issue(enc_i(3'd2, 5'd2, 5'd1, 12'hFFB), 0, 1, 0, 5'd2, 32'd0, "R5 slti 5<-5");
    issue(enc_i(3'd3, 5'd2, 5'd1, 12'hFFB), 0, 1, 0, 5'd2, 32'd1, "R5 sltiu 5<big");
    set_reg(5'd1, 32'hFFFFFFEC);
    issue(enc_i(3'd2, 5'd2, 5'd1, 12'hFFB), 0, 1, 0, 5'd2, 32'd1, "R5 slti -20<-5");

    // R2 logic immediates
    set_reg(5'd1, 32'd6);
    issue(enc_i(3'd4, 5'd2, 5'd1, 12'd12), 0, 1, 0, 5'd2, 32'd10, "R2 xori");
    issue(enc_i(3'd6, 5'd2, 5'd1, 12'd12), 0, 1, 0, 5'd2, 32'd14, "R2 ori");
    issue(enc_i(3'd7, 5'd2, 5'd1, 12'd12), 0, 1, 0, 5'd2, 32'd4,  "R2 andi");

    // R4 shifts
    issue(enc_i(3'd1, 5'd2, 5'd1, 12'd2),    0, 1, 0, 5'd2, 32'd24, "R4 slli 2");
    issue(enc_i(3'd1, 5'd2, 5'd1, 12'h022),  0, 1, 0, 5'd2, 32'd24, "R4 slli upper ignored");
    issue(enc_i(3'd5, 5'd2, 5'd1, 12'd2),    0, 1, 0, 5'd2, 32'd1,  "R4 srli 2");
    issue(enc_i(3'd5, 5'd2, 5'd1, 12'h402),  0, 1, 0, 5'd2, 32'd1,  "R3 srai positive");
    set_reg(5'd1, 32'hFFFFFFFA);
    issue(enc_i(3'd5, 5'd2, 5'd1, 12'd2),    0, 1, 0, 5'd2, 32'h3FFFFFFE, "R4 srli neg");
    issue(enc_i(3'd5, 5'd2, 5'd1, 12'h402),  0, 1, 0, 5'd2, 32'hFFFFFFFE, "R3 srai neg");
    issue(enc_i(3'd5, 5'd2, 5'd1, 12'h400),  0, 1, 0, 5'd2, 32'hFFFFFFFA, "R4 srai zero");
    issue(enc_i(3'd5, 5'd2, 5'd1, 12'h000),  0, 1, 0, 5'd2, 32'hFFFFFFFA, "R4 srli zero");

    // R7
    issue(32'h0007B0B7, 0,  1, 0, 5'd1, 32'd503808, "R7 lui");
    issue(32'h0007B097, 0,  1, 0, 5'd1, 32'd503808, "R7 auipc pc0");
    issue(32'h0007B097, 12, 1, 0, 5'd1, 32'd503820, "R7 auipc pc12");

    // R2 R3 register-register
    set_reg(5'd1, 32'd3);
    set_reg(5'd2, 32'd4);
    set_reg(5'd4, 32'hFFFFFFFF);
    issue(enc_r(7'h00, 3'd0, 5'd3, 5'd1, 5'd2), 0, 1, 0, 5'd3, 32'd7, "R2 add");
    issue(enc_r(7'h20, 3'd0, 5'd3, 5'd1, 5'd2), 0, 1, 0, 5'd3, 32'hFFFFFFFF, "R3 sub");
    issue(enc_r(7'h00, 3'd2, 5'd3, 5'd1, 5'd2), 0, 1, 0, 5'd3, 32'd1, "R5 slt 3<4");
    issue(enc_r(7'h00, 3'd2, 5'd3, 5'd1, 5'd4), 0, 1, 0, 5'd3, 32'd0, "R5 slt 3<-1");
    issue(enc_r(7'h00, 3'd3, 5'd3, 5'd1, 5'd4), 0, 1, 0, 5'd3, 32'd1, "R5 sltu 3<max");
    issue(enc_r(7'h00, 3'd3, 5'd3, 5'd2, 5'd1), 0, 1, 0, 5'd3, 32'd0, "R5 sltu 4<3");
    set_reg(5'd1, 32'd6);
    set_reg(5'd2, 32'd12);
    issue(enc_r(7'h00, 3'd6, 5'd3, 5'd1, 5'd2), 0, 1, 0, 5'd3, 32'd14, "R2 or");
    issue(enc_r(7'h00, 3'd4, 5'd3, 5'd1, 5'd2), 0, 1, 0, 5'd3, 32'd10, "R2 xor");
    issue(enc_r(7'h00, 3'd7, 5'd3, 5'd1, 5'd2), 0, 1, 0, 5'd3, 32'd4,  "R2 and");
    set_reg(5'd5, 32'h00000022);
    issue(enc_r(7'h00, 3'd1, 5'd3, 5'd1, 5'd5), 0, 1, 0, 5'd3, 32'd24, "R4 sll upper ignored");
    set_reg(5'd1, 32'hFFFFFFFA);
    set_reg(5'd2, 32'd2);
    issue(enc_r(7'h00, 3'd5, 5'd3, 5'd1, 5'd2), 0, 1, 0, 5'd3, 32'h3FFFFFFE, "R4 srl neg");
    issue(enc_r(7'h20, 3'd5, 5'd3, 5'd1, 5'd2), 0, 1, 0, 5'd3, 32'hFFFFFFFE, "R3 sra neg");

    // R8
    issue(enc_i(3'd0, 5'd0, 5'd0, 12'd5), 0, 1, 0, 5'd0, 32'd0, "R8 x0 write dropped");
    issue(enc_r(7'h00, 3'd0, 5'd3, 5'd0, 5'd0), 0, 1, 0, 5'd3, 32'd0, "R8 x0 reads zero");

    // R9 valid low
    set_reg(5'd7, 32'd77);
    issue(enc_i(3'd0, 5'd7, 5'd0, 12'd99), 0, 0, 0, 5'd7, 32'd77, "R9 no write when idle");

    // R1 illegal opcode, also while idle
    issue({20'h00063, 5'd7, 7'h03}, 0, 1, 1, 5'd7, 32'd77, "R1 illegal opcode");
    issue({20'h00063, 5'd7, 7'h6F}, 0, 0, 0, 5'd7, 32'd77, "R1 illegal idle");

    // R10 back-to-back dependency
    issue(enc_i(3'd0, 5'd6, 5'd0, 12'd1), 0, 1, 0, 5'd6, 32'd1, "R10 chain 1");
    issue(enc_i(3'd0, 5'd6, 5'd6, 12'd1), 0, 1, 0, 5'd6, 32'd2, "R10 chain 2");
    issue(enc_i(3'd0, 5'd6, 5'd6, 12'd1), 0, 1, 0, 5'd6, 32'd3, "R10 chain 3");

    @(negedge clk_i);
    valid_i = 1'b0;
    while (sb.size() > 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule